// File: doc/BRIEF.md
# Printer Port Control Register

This block holds the 8-bit control byte of a PC-style printer port. A host writes it over a small synchronous register bus and reads it back on the same bus. Four of its bits drive the printer handshake pins. Three of those pins are active low and one is not, so each bit carries its own polarity onto its pin.

A fifth bit gates an interrupt request. The request is raised by a rising edge on the printer's acknowledge input. The block first brings that input into its own clock domain, then turns each rising edge into a one-cycle pulse on the interrupt output.

A sixth bit picks the data-bus direction. That bit is honoured only while the port runs in extended mode. In plain printer mode the direction is always output. The two top bits are unused: they read as zero and ignore writes.

Top module: `lpt_ctrl_reg`

## Requirements
- R1: `strobe_n` is the inverse of bit 0 of the control byte.
- R2: `autofd_n` is the inverse of bit 1, so writing 1 to bit 1 requests an automatic line feed (pin low).
- R3: `init_n` follows bit 2 without inversion.
- R4: `selectin_n` is the inverse of bit 3, so writing 1 to bit 3 selects the printer (pin low).
- R5: With bit 4 set, a rising edge on `ack_n` produces `irq` high for exactly one clock cycle. The pulse comes after the third rising clock edge following the change of `ack_n`. A falling edge on `ack_n` produces no pulse.
- R6: With bit 4 clear, `irq` stays low whatever `ack_n` does.
- R7: With `ext_mode` = 1, `data_dir_in` equals bit 5 (0 means output, 1 means input). With `ext_mode` = 0, `data_dir_in` is 0 regardless of bit 5.
- R8: Bits 7 and 6 ignore writes and always read back as 0.
- R9: Reset clears bits 5 to 0. The pins then read `strobe_n`=1, `autofd_n`=1, `init_n`=0, `selectin_n`=1, `data_dir_in`=0 and `irq`=0.
- R10: A write takes effect at the clock edge where `bus_wr` is high and `bus_addr` equals `CTRL_ADDR` (default 2). While `bus_addr` equals `CTRL_ADDR`, `bus_rdata` returns bits 5 to 0 exactly as last written. At any other address `bus_rdata` is 0, and writes there leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| ext_mode | input | 1 | 1 = extended (bidirectional) mode, 0 = plain printer mode |
| ack_n | input | 1 | Printer acknowledge, asynchronous |
| strobe_n | output | 1 | Strobe pin |
| autofd_n | output | 1 | Auto line feed pin |
| init_n | output | 1 | Initialise pin |
| selectin_n | output | 1 | Printer select pin |
| data_dir_in | output | 1 | Data-bus direction, 1 = input |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `bus_wr`, `bus_addr`, `bus_wdata` and `ext_mode` are steady around each rising clock edge. They also assume that `ack_n` holds each level for at least one full clock cycle, so that the synchronizer sees every edge.

The bench drives every input at the falling clock edge and holds `ack_n` levels for several cycles. It mixes random writes to random addresses, with a random mode, with directed acknowledge pulses whose interrupt cycle is counted from the edge where `ack_n` changes.

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg #(
  parameter int unsigned ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ext_mode,
  input  logic              ack_n,
  output logic              strobe_n,
  output logic              autofd_n,
  output logic              init_n,
  output logic              selectin_n,
  output logic              data_dir_in,
  output logic              irq
);

  localparam int unsigned CW = 6;

  logic [CW-1:0]          ctrl_q;
  logic [SYNC_STAGES-1:0] ack_sync_q;
  logic                   ack_prev_q;
  logic                   sel;
  logic                   ack_s;
  logic                   ack_rise;

  assign sel   = (bus_addr == CTRL_ADDR);
  assign ack_s = ack_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrl_q <= '0;
    else if (bus_wr && sel) ctrl_q <= bus_wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sync_q <= '1;
      ack_prev_q <= 1'b1;
      irq        <= 1'b0;
    end else begin
      ack_sync_q <= {ack_sync_q[SYNC_STAGES-2:0], ack_n};
      ack_prev_q <= ack_s;
      irq        <= ack_rise & ctrl_q[4];
    end
  end

  assign ack_rise = ack_s & ~ack_prev_q;

  assign bus_rdata   = sel ? {{(8-CW){1'b0}}, ctrl_q} : 8'h00;
  assign strobe_n    = ~ctrl_q[0];
  assign autofd_n    = ~ctrl_q[1];
  assign init_n      =  ctrl_q[2];
  assign selectin_n  = ~ctrl_q[3];
  assign data_dir_in = ext_mode & ctrl_q[5];

  // R5
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_q[4]));

  // R7
  dir_forced_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> !data_dir_in);

  // R10
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel) |=> (ctrl_q == $past(bus_wdata[CW-1:0])));

  // R1
  strobe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel) |=> (strobe_n == !$past(bus_wdata[0])));

  // R8
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:6] == 2'b00);

endmodule

// File: tb/lpt_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module lpt_ctrl_reg_tb_top;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] CA = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic ext_mode = 1'b0, ack_n = 1'b1;
  logic strobe_n, autofd_n, init_n, selectin_n, data_dir_in, irq;

  int vecs = 0, bad = 0;
  logic [5:0] m_ctrl = '0;

  always #10 clk = ~clk;

  lpt_ctrl_reg #(.ADDR_W(AW), .CTRL_ADDR(CA), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_mode(ext_mode),
    .ack_n(ack_n), .strobe_n(strobe_n), .autofd_n(autofd_n), .init_n(init_n),
    .selectin_n(selectin_n), .data_dir_in(data_dir_in), .irq(irq));

  function automatic logic [4:0] exp_pins(logic [5:0] c, logic em);
    return {~c[0], ~c[1], c[2], ~c[3], em & c[5]};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_pins(string req);
    check(req, {3'b0, strobe_n, autofd_n, init_n, selectin_n, data_dir_in},
          {3'b0, exp_pins(m_ctrl, ext_mode)});
  endtask

  task automatic write_reg(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a == CA) m_ctrl = d[5:0];
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = CA;
    #1;
  endtask

  task automatic ack_edge(logic en, logic rising);
    int got;
    write_reg(CA, {2'b0, 1'b0, en, 4'h0});
    ack_n = rising ? 1'b0 : 1'b1;
    repeat (5) @(negedge clk);
    ack_n = rising ? 1'b1 : 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R5 early", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check(en && rising ? "R5 pulse" : "R6 quiet", {7'b0, irq},
          {7'b0, en & rising});
    @(negedge clk);
    check("R5 width", {7'b0, irq}, 8'h00);
    got = 0;
    repeat (6) begin @(negedge clk); got += irq; end
    check("R5 no extra", got[7:0], 8'h00);
    ack_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    bus_addr = CA; ext_mode = 1'b1; #1;
    check("R9 rdata", bus_rdata, 8'h00);
    check("R9 pins", {3'b0, strobe_n, autofd_n, init_n, selectin_n, data_dir_in},
          8'b000_11010);
    check("R9 irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;

    // directed corners
    write_reg(CA, 8'hFF);
    check("R8 top bits", bus_rdata, 8'h3F);
    check_pins("R1 R2 R3 R4 R7 all ones");
    ext_mode = 1'b0; #1;
    check("R7 printer mode forces out", {7'b0, data_dir_in}, 8'h00);
    ext_mode = 1'b1; #1;
    check("R7 ext mode follows bit", {7'b0, data_dir_in}, 8'h01);
    write_reg(3'd5, 8'h00);
    check("R10 other addr write ignored", bus_rdata, 8'h3F);
    bus_addr = 3'd5; #1;
    check("R10 other addr reads 0", bus_rdata, 8'h00);
    bus_addr = CA;
    write_reg(CA, 8'hC0);
    check("R8 write of top bits only", bus_rdata, 8'h00);
    check_pins("R1 R2 R3 R4 zero");

    ack_edge(1'b1, 1'b1);
    ack_edge(1'b0, 1'b1);
    ack_edge(1'b1, 1'b0);
    ack_edge(1'b1, 1'b1);

    for (int i = 0; i < 400; i++) begin
      ext_mode = 1'($urandom);
      write_reg(AW'($urandom), 8'($urandom));
      check("R10 readback", bus_rdata, {2'b0, m_ctrl});
      check_pins("R1 R2 R3 R4 R7 random");
      check("R6 no ack edge", {7'b0, irq}, 8'h00);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule